// File: doc/BRIEF.md
# Speculative Fetch Throttle

This block decides, every cycle, whether instruction fetch should pause because too many doubtful branch predictions are still awaiting resolution. Each branch prediction carries a one-bit confidence tag: high (the prediction is probably right) or low (it is probably wrong). When a low-confidence branch leaves the decode stage, an internal counter grows by one. When the execute stage resolves a branch that still carries a low tag, the counter shrinks by one. A misprediction flush squashes every younger branch, so it empties the counter.

The count is compared against a 3-bit threshold that software or a mode controller may change on any cycle. Fetch is held only while the count is strictly greater than the threshold. The comparison is registered, so the fetch unit sees the stall one cycle after the count moves across the threshold. A flush releases the stall in the same cycle it arrives. This keeps wrong-path instructions out of the pipeline and leaves paths that were predicted correctly at full speed.

Top module: `fetch_throttle_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_stall_o` is 0 and the internal count is zero.
- R2: A cycle with `dec_br_valid_i`=1 and `dec_br_lowconf_i`=1 (1 = low confidence, 0 = high) adds one to the count. A decoded branch tagged high confidence does not change the count.
- R3: A cycle with `res_br_valid_i`=1 and `res_br_lowconf_i`=1 subtracts one from the count. A resolved branch tagged high confidence does not change the count.
- R4: An increment and a decrement in the same cycle leave the count unchanged.
- R5: When there is no flush, `fetch_stall_o` in cycle t+1 equals (count in cycle t > `thr_i` in cycle t). It is driven by a register, one cycle behind the count.
- R6: A count equal to the threshold does not stall fetch.
- R7: `flush_i`=1 clears the count to zero on the next edge and forces `fetch_stall_o` low in the same cycle and in the cycle after. A branch decoded during the flush cycle is not counted.
- R8: The count saturates at its maximum (7 with the default width). Further increments are lost and do not wrap to zero.
- R9: The count saturates at zero. A low-tag resolution at zero is lost and does not wrap to the maximum.
- R10: The threshold is sampled every cycle. A threshold of 7 (all ones) never produces a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_br_valid_i | input | 1 | A predicted branch leaves decode this cycle |
| dec_br_lowconf_i | input | 1 | Confidence tag of that branch, 1 = low |
| res_br_valid_i | input | 1 | A branch resolves in execute this cycle |
| res_br_lowconf_i | input | 1 | Tag the resolving branch carried, 1 = low |
| flush_i | input | 1 | Misprediction flush, squashes all younger branches |
| thr_i | input | 3 | Stall threshold N, stall when count > N |
| fetch_stall_o | output | 1 | Hold instruction fetch |

## Verification
The bench aims at the threshold boundary: a design that compares with greater-or-equal would stall one branch early, when the count equals N. It drives the counter into both rails and then steps it back. A counter that wraps would show a stall pattern that is off by a full range. It also checks that a threshold of all ones stays open even with a full count.

Flushes are sent while a stall is active and together with a low-confidence decode. A design that releases the stall only after the register updates would hold fetch for one cycle too long. A design that counts the squashed branch would stall afterwards with no reason. Cycles with both an increment and a decrement, and resolutions tagged high confidence, catch designs that let those cycles move the count.

// File: rtl/fetch_throttle_pkg.sv
// Shared types for the speculative fetch throttle.
package fetch_throttle_pkg;

    // Confidence tag carried by every predicted branch.
    typedef enum logic {
        CONF_HIGH = 1'b0,
        CONF_LOW  = 1'b1
    } conf_e;

    // True when a valid branch event carries a low-confidence tag.
    function automatic logic is_low_event(input logic valid, input conf_e tag);
        return valid && (tag == CONF_LOW);
    endfunction

endpackage

// File: rtl/lc_branch_counter.sv
// Saturating up/down counter of in-flight low-confidence branches.
// Assumes: at most one increment and one decrement request per cycle;
// clear has priority over both (flush squashes the decoding branch too).
module lc_branch_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_i,
    input  logic             sub_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt_q;
    logic             up_ok;
    logic             down_ok;

    // Decide whether a one-sided step may be taken without leaving the range.
    always_comb begin
        up_ok   = add_i && !sub_i && (cnt_q != CNT_MAX);
        down_ok = sub_i && !add_i && (cnt_q != CNT_ZERO);
    end

    // Hold the count, clearing on flush and saturating at both rails.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
        end else if (clear_i) begin
            cnt_q <= CNT_ZERO;
        end else if (up_ok) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (down_ok) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count_o = cnt_q;

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == CNT_ZERO));

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == CNT_ZERO));

    assert_balanced_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && sub_i && !clear_i) |=> $stable(cnt_q));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && add_i && !clear_i) |=> (cnt_q == CNT_MAX));

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_ZERO && sub_i) |=> (cnt_q == CNT_ZERO));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_i && !sub_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/gate_decision.sv
// Registered threshold compare that produces the fetch stall.
// Assumes: threshold and count share a width, so an all-ones threshold
// can never be exceeded. A flush releases the stall combinationally.
module gate_decision #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] thr_i,
    input  logic             flush_i,
    output logic             stall_o
);
    localparam logic [CNT_W-1:0] THR_MAX = '1;

    logic stall_q;

    // Register the strict compare; a flush empties the pipe, so no stall follows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
        end else if (flush_i) begin
            stall_q <= 1'b0;
        end else begin
            stall_q <= (count_i > thr_i);
        end
    end

    // Release fetch in the very cycle a flush arrives.
    always_comb begin
        stall_o = stall_q && !flush_i;
    end

    assert_gt_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i > thr_i && !flush_i) |=> stall_q);

    assert_equal_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == thr_i && !flush_i) |=> !stall_q);

    assert_flush_next_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !stall_o);

    assert_max_thr_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_i == THR_MAX) |=> !stall_q);

endmodule

// File: rtl/fetch_throttle_ctl.sv
// Top of the speculative fetch throttle: counts unresolved low-confidence
// branches and holds fetch while that count exceeds a per-cycle threshold.
// Assumes: one decode and one resolve event per cycle at most; flush squashes
// every branch younger than the mispredicted one, including one in decode.
module fetch_throttle_ctl
    import fetch_throttle_pkg::*;
#(
    parameter int THR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_br_valid_i,
    input  logic             dec_br_lowconf_i,
    input  logic             res_br_valid_i,
    input  logic             res_br_lowconf_i,
    input  logic             flush_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             fetch_stall_o
);
    logic             add_req;
    logic             sub_req;
    logic [THR_W-1:0] lc_count;

    // Turn branch events into counter step requests.
    always_comb begin
        add_req = is_low_event(dec_br_valid_i, conf_e'(dec_br_lowconf_i));
        sub_req = is_low_event(res_br_valid_i, conf_e'(res_br_lowconf_i));
    end

    lc_branch_counter #(.CNT_W(THR_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_i   (add_req),
        .sub_i   (sub_req),
        .clear_i (flush_i),
        .count_o (lc_count)
    );

    gate_decision #(.CNT_W(THR_W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (lc_count),
        .thr_i   (thr_i),
        .flush_i (flush_i),
        .stall_o (fetch_stall_o)
    );

    assert_reset_open_R1: assert property (@(posedge clk)
        !rst_n |=> !fetch_stall_o);

    assert_high_dec_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_br_valid_i && !dec_br_lowconf_i && !res_br_valid_i && !flush_i)
        |=> $stable(lc_count));

    assert_high_res_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_br_valid_i && !res_br_lowconf_i && !dec_br_valid_i && !flush_i)
        |=> $stable(lc_count));

endmodule

// File: tb/fetch_throttle_ctl_test.sv
module fetch_throttle_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dv = 1'b0, dl = 1'b0, rv = 1'b0, rl = 1'b0, fl = 1'b0;
    logic [2:0] thr = 3'd0;
    logic       stall;

    int checks = 0;
    int failures = 0;
    int m_cnt = 0;
    bit m_stall = 1'b0;
    string tag = "R1";

    always #2 clk = ~clk;

    fetch_throttle_ctl uut (
        .clk(clk), .rst_n(rst_n),
        .dec_br_valid_i(dv), .dec_br_lowconf_i(dl),
        .res_br_valid_i(rv), .res_br_lowconf_i(rl),
        .flush_i(fl), .thr_i(thr), .fetch_stall_o(stall)
    );

    task automatic check(input bit exp);
        checks++;
        if (stall !== exp) begin
            failures++;
            $display("FAIL %s: fetch_stall_o actual=%b expected=%b at %0t", tag, stall, exp, $time);
        end
    endtask

    // One cycle: drive after the falling edge, check, then advance the model at the rising edge.
    task automatic step(input bit d_v, input bit d_l, input bit r_v, input bit r_l,
                        input bit f, input int t);
        @(negedge clk);
        dv = d_v; dl = d_l; rv = r_v; rl = r_l; fl = f; thr = 3'(t);
        #1;
        check(m_stall && !f);
        @(posedge clk);
        begin
            bit inc = d_v && d_l;
            bit dec = r_v && r_l;
            bit nstall = f ? 1'b0 : (m_cnt > t);
            if (f) m_cnt = 0;
            else if (inc && !dec && m_cnt < 7) m_cnt++;
            else if (dec && !inc && m_cnt > 0) m_cnt--;
            m_stall = nstall;
        end
    endtask

    task automatic idle(input int t, input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, t);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            tag = "R1"; check(1'b0);
        end
        @(negedge clk); rst_n = 1'b1;
        tag = "R1"; idle(0, 2);

        tag = "R2";                       // high-confidence decodes do not count
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);
        idle(0, 2);
        step(1, 1, 0, 0, 0, 0);           // one low-confidence branch: 1 > 0
        idle(0, 3);

        tag = "R3";                       // high-tag resolutions leave the count
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);
        idle(0, 2);
        step(0, 0, 1, 1, 0, 0);           // low-tag resolution empties it
        idle(0, 3);

        tag = "R4";
        step(1, 1, 0, 0, 0, 1);
        step(1, 1, 0, 0, 0, 1);           // count 2 > 1
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 1);
        idle(1, 2);

        tag = "R6";
        step(1, 1, 0, 0, 0, 3);           // count 3 equals threshold 3
        idle(3, 3);
        step(1, 1, 0, 0, 0, 3);           // count 4 > 3
        idle(3, 3);

        tag = "R7";                       // flush while stalled, with a low decode in the same cycle
        step(1, 1, 0, 0, 1, 0);
        idle(0, 3);
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, 0);
        idle(0, 2);
        step(0, 0, 0, 0, 1, 0);
        idle(0, 3);

        tag = "R8";                       // push past the top, step back once
        for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 0, 6);
        idle(6, 2);
        step(0, 0, 1, 1, 0, 6);           // count 6 equals threshold 6
        idle(6, 3);
        step(0, 0, 0, 0, 1, 6);

        tag = "R9";                       // pull below zero, then one increment
        for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 0, 0);
        step(1, 1, 0, 0, 0, 0);
        idle(0, 3);
        step(0, 0, 0, 0, 1, 0);

        tag = "R10";                      // full count never exceeds an all-ones threshold
        for (int i = 0; i < 9; i++) step(1, 1, 0, 0, 0, 7);
        idle(7, 3);
        step(0, 0, 0, 0, 0, 2);           // threshold changes take effect per cycle
        idle(2, 2);
        idle(7, 3);

        tag = "R5";                       // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int t = $urandom_range(0, 7);
            step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                 $urandom_range(0, 2) != 0, $urandom_range(0, 40) == 0, t);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule